// File: doc/BRIEF.md
# Chained Panel Switch Capture Register

This block sits on a panel input board. It samples a group of panel switch lines and returns them to a master controller over a serial link that runs through several boards in a chain. Each board's serial input takes the previous board's serial output. The boards therefore behave as one long shift register. The master reads every board in a single continuous transfer and tells boards apart by their position in the chain.

The block runs on a local system clock. It resynchronises the serial clock, the select line, the serial data and the switch lines before using any of them.

When the select line goes low, the block copies the synchronised switch levels into a 16-bit register. Bits that have no switch attached are forced to zero. While the select line stays low, each rising edge of the serial clock shifts the register one place toward the output. The bit shifted out goes downstream, and the upstream bit enters at the bottom.

The board's indicator LEDs repeat the switch lines directly, without involving the master. A high switch level means the turnout is thrown (diverging). A low level means it is closed (straight through).

Top module: `sw_chain_shifter`

## Requirements
- R1: After reset the register holds all zeros, so the serial output is 0 on both boards of a chain.
- R2: A high-to-low transition of the select line loads the synchronised switch levels into bits SW_N-1:0. Switch i lands in bit i, where 1 means thrown and 0 means closed. A switch held stable for at least four system clocks before the select falls is the value captured.
- R3: After a load, bits PORT_W-1:SW_N (15:8 by default) read as 0.
- R4: While the select line is low, each rising serial-clock edge shifts the register toward its MSB. The serial input enters bit 0. The serial output always shows the MSB, so a 16-bit read returns bit 15 first.
- R5: While the select line is high, serial-clock edges and serial-input changes have no effect, and the serial output holds its last value.
- R6: When two boards are chained, a 32-bit transfer returns the downstream board's word first and then the upstream board's word. Afterwards, the downstream board holds the first 16 bits the master sent.
- R7: Each LED output equals its switch input combinationally, whatever the state of the serial link.
- R8: If the select line rises part-way through a transfer, shifting stops with the partly shifted contents held. The next falling select reloads fresh switch levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from master (asynchronous) |
| ss_n | input | 1 | Active-low select from master (asynchronous) |
| mosi | input | 1 | Serial data from upstream board or master |
| sw | input | SW_N | Panel switch levels, high means thrown |
| miso | output | 1 | Serial data toward downstream board or master |
| led | output | SW_N | Local indicator drive, mirrors sw |

## Verification
The assertions assume two things about the serial link. First, the serial clock, the select and the serial input each stay stable for several system clocks around their edges, so that the synchronised copies change one at a time. Second, the serial input is steady when the synchronised serial-clock edge is seen. The stimulus meets these conditions by holding every serial phase for eight system clocks. It changes data only while the serial clock is low, and it changes the switch levels well before the select falls. Chained boards get the same synchroniser latency on data and clock, so the bench keeps both boards on shared clock and select lines.

// File: rtl/sw_chain_shifter.sv
module sw_chain_shifter #(
  parameter int SW_N   = 8,
  parameter int PORT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            ss_n,
  input  logic            mosi,
  input  logic [SW_N-1:0] sw,
  output logic            miso,
  output logic [SW_N-1:0] led
);

  logic [SW_N-1:0]   sw_m, sw_s;
  logic              ss_m, ss_s, ss_d;
  logic              ck_m, ck_s, ck_d;
  logic              mo_m, mo_s;
  logic [PORT_W-1:0] sreg;
  logic [PORT_W-1:0] load_w;
  logic              ss_fall, ck_rise;

  assign ss_fall = ss_d & ~ss_s;
  assign ck_rise = ck_s & ~ck_d;
  assign miso    = sreg[PORT_W-1];
  assign led     = sw;

  always_comb begin
    load_w = '0;
    load_w[SW_N-1:0] = sw_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_m <= '0;  sw_s <= '0;
      ss_m <= 1'b1; ss_s <= 1'b1; ss_d <= 1'b1;
      ck_m <= 1'b0; ck_s <= 1'b0; ck_d <= 1'b0;
      mo_m <= 1'b0; mo_s <= 1'b0;
      sreg <= '0;
    end else begin
      sw_m <= sw;   sw_s <= sw_m;
      ss_m <= ss_n; ss_s <= ss_m; ss_d <= ss_s;
      ck_m <= sclk; ck_s <= ck_m; ck_d <= ck_s;
      mo_m <= mosi; mo_s <= mo_m;
      if (ss_fall)
        sreg <= load_w;
      else if (!ss_s && ck_rise)
        sreg <= {sreg[PORT_W-2:0], mo_s};
    end
  end

  // R2
  load_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_fall |=> sreg[SW_N-1:0] == $past(sw_s));

  // R3
  load_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_fall |=> (sreg >> SW_N) == '0);

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_rise && !ss_s && !ss_d) |=>
      (sreg[0] == $past(mo_s)) && (sreg[PORT_W-1:1] == $past(sreg[PORT_W-2:0])));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> $stable(sreg));

  // R5
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_s && ss_d) |=> $stable(miso));

endmodule

// File: tb/sim_sw_chain_shifter.sv
module sim_sw_chain_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, ss_n = 1'b1, m_mosi = 1'b0;
  logic [7:0] sw_a = '0, sw_b = '0;
  logic miso_a, miso_b;
  logic [7:0] led_a, led_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sw_chain_shifter u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n),
    .mosi(m_mosi), .sw(sw_a), .miso(miso_a), .led(led_a));
  sw_chain_shifter u1 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n),
    .mosi(miso_a), .sw(sw_b), .miso(miso_b), .led(led_b));

  typedef struct packed { logic [7:0] sw; logic [15:0] mo; logic [15:0] exp; } vec_t;
  localparam vec_t VECS [4] = '{
    '{8'hA5, 16'h8001, 16'h00A5},
    '{8'hFF, 16'h7FFE, 16'h00FF},
    '{8'h00, 16'hC3C3, 16'h0000},
    '{8'h81, 16'h1234, 16'h0081}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift(input int n, input logic [31:0] mo,
                       output logic [31:0] ga, output logic [31:0] gb);
    ga = '0; gb = '0;
    for (int i = 0; i < n; i++) begin
      ga = {ga[30:0], miso_a};
      gb = {gb[30:0], miso_b};
      m_mosi = mo[n-1-i];
      wt(8); sclk = 1'b1;
      wt(8); sclk = 1'b0;
    end
  endtask

  task automatic xfer(input int n, input logic [31:0] mo,
                      output logic [31:0] ga, output logic [31:0] gb);
    ss_n = 1'b0; wt(8);
    shift(n, mo, ga, gb);
    wt(8); ss_n = 1'b1; wt(8);
  endtask

  initial begin
    logic [31:0] ga, gb;
    logic held;
    wt(3); rst_n = 1'b1; wt(4);
    // R1 reset state
    chk("R1 miso_a", miso_a, 0);
    chk("R1 miso_b", miso_b, 0);

    foreach (VECS[k]) begin
      sw_a = VECS[k].sw; wt(6);
      xfer(16, VECS[k].mo, ga, gb);
      chk("R2/R3 read", ga[15:0], VECS[k].exp);
      chk("R4 shifted-in msb", miso_a, VECS[k].mo[15]);
      held = miso_a;
      for (int j = 0; j < 3; j++) begin
        m_mosi = ~m_mosi; wt(8); sclk = 1'b1; wt(8); sclk = 1'b0;
      end
      wt(4);
      chk("R5 idle hold", miso_a, held);
    end

    // R4 second read returns previously shifted word after reload? reload instead
    sw_a = 8'h3C; wt(6);
    xfer(16, 32'h0, ga, gb);
    chk("R4 bit order", ga[15:0], 16'h003C);

    // R7 led mirror
    sw_a = 8'h5A; sw_b = 8'hC3; #1;
    chk("R7 led_a", led_a, 8'h5A);
    chk("R7 led_b", led_b, 8'hC3);
    ss_n = 1'b0; sw_a = 8'h0F; #1;
    chk("R7 led while selected", led_a, 8'h0F);
    ss_n = 1'b1; wt(10);

    // R6 two-board chain
    sw_a = 8'h96; sw_b = 8'h4B; wt(6);
    xfer(32, 32'hBEEF_1234, ga, gb);
    chk("R6 chain read", gb, 32'h004B_0096);
    chk("R6 downstream holds master head", miso_b, 1'b1);
    chk("R6 upstream holds master tail", miso_a, 1'b0);

    // R8 abort mid-transfer then reload
    sw_a = 8'hF0; wt(6);
    ss_n = 1'b0; wt(8);
    shift(4, 32'hF, ga, gb);
    wt(8); ss_n = 1'b1; wt(8);
    chk("R8 partial read", ga[3:0], 4'h0);
    chk("R8 held after abort", miso_a, 1'b0);
    sw_a = 8'h77; wt(6);
    xfer(16, 32'h0, ga, gb);
    chk("R8 fresh reload", ga[15:0], 16'h0077);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule